// File: doc/BRIEF.md
# Multi-channel PWM waveform generator

The block holds a bank of independent pulse-width modulation channels, each driving one output pin. A channel divides the system clock by a linear factor and a power-of-two factor, steps an 8-bit counter once per divided tick, and wraps that counter after a programmed terminal value. Two compare points on the counter set where the output turns active and where it turns inactive. Equal compare points give a constantly active output.

Software programs each channel through a plain word-wide write/read port. Per channel there is a control word (dividers, output enables, inversion, clock gate, update mode) and a waveform word (compare points and terminal count). The divider, terminal and compare settings pass through a shadow stage. By default that stage is reloaded only where one PWM period ends and the next begins, so a period never mixes old and new settings. An update-mode bit makes new settings take hold on the next clock instead.

Gating of the waveform (clock gate), of the pin (pin enable) and inversion act on the output without waiting for a period boundary. The open-drain option turns the pin output-enable into a pull-low-only drive.

Top module: `pwm_bank`

## Requirements
- R1: With linear divider L (control bits 7:0), power-of-two exponent H (control bits 11:8) and terminal count P (waveform bits 31:24), the output repeats every (L+1)·2^H·(P+1) clock cycles.
- R2: With rise point R (waveform bits 7:0) different from fall point F (waveform bits 15:8), the output is active for counter values from R up to F-1. When R>F this range wraps through the terminal count. The high time is therefore ((F-R) mod (P+1)) counter steps.
- R3: When R equals F and the clock gate (control bit 16) is set, the output is constantly active.
- R4: While the clock gate is clear, the counter and prescaler stay at zero and the waveform is forced inactive. Writes made meanwhile are accepted and take effect once the gate is set again.
- R5: While pin enable (control bit 12) is clear, the pin drives low (data 0, output-enable 1) whatever the other settings are.
- R6: The invert bit (control bit 14) flips the output on the clock after the write, with no wait for a period boundary.
- R7: With the update-mode bit (control bit 17) clear, new divider, terminal and compare values do not alter the period that is running. They are loaded where the counter wraps from P to 0.
- R8: With the update-mode bit set, new values are loaded into the shadow stage on the clock after the write.
- R9: Channel c has its control word at byte address c·0x10 and its waveform word at c·0x10+0x04. Unused bits (control 15 and 31:18, waveform 23:16) read back as zero.
- R10: With the open-drain bit (control bit 13) set, output-enable is high only while the pin data is low. Without it, output-enable is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the prescaler source |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte address of the word to write or read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pwm_out | output | N_CH | Pin data, one bit per channel |
| pwm_oe | output | N_CH | Pin output-enable, one bit per channel |

## Verification
The bound checker watches the pin-level gating on every cycle: pin-disable forcing a driven low, the clock gate forcing an inactive level, the open-drain and push-pull output-enable relation, and a constant active level whenever the compare points are equal and settled. Period length, high time and the wrapped active window can only be shown by the bench, which measures edges on the pins for several divider and compare settings. The same holds for the boundary-deferred load against the immediate load, the latency of inversion and the register read-back masking.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

   // control word bit positions (software-visible layout)
   localparam int C_DIVL_LSB = 0;
   localparam int C_DIVH_LSB = 8;
   localparam int C_PIN      = 12;
   localparam int C_OD       = 13;
   localparam int C_INV      = 14;
   localparam int C_RUN      = 16;
   localparam int C_NOSYNC   = 17;

   // waveform word bit positions
   localparam int W_RISE_LSB = 0;
   localparam int W_FALL_LSB = 8;
   localparam int W_TERM_LSB = 24;

   localparam int DIVL_W = 8;
   localparam int DIVH_W = 4;
   localparam int CNT_W  = 8;

   typedef struct packed {
      logic              nosync;
      logic              run;
      logic              inv;
      logic              od;
      logic              pin;
      logic [DIVH_W-1:0] divh;
      logic [DIVL_W-1:0] divl;
   } ctrl_t;

   typedef struct packed {
      logic [CNT_W-1:0] term;
      logic [CNT_W-1:0] fall;
      logic [CNT_W-1:0] rise;
   } wave_t;

   // settings that pass through the shadow stage
   typedef struct packed {
      logic [DIVH_W-1:0] divh;
      logic [DIVL_W-1:0] divl;
      wave_t             wave;
   } shadow_t;

endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
   import pwm_bank_pkg::*;
#(
   parameter int N_CH      = 16,
   parameter int ADDR_W    = 8,
   parameter int SLOT_BYTES = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [31:0]          wdata,
   output logic [31:0]          rdata,
   output ctrl_t [N_CH-1:0]     ctrl_q,
   output wave_t [N_CH-1:0]     wave_q
);

   localparam int SLOT_W = $clog2(SLOT_BYTES);
   localparam int IDX_W  = ADDR_W - SLOT_W;
   localparam logic [SLOT_W-1:0] OFF_CTRL = SLOT_W'(0);
   localparam logic [SLOT_W-1:0] OFF_WAVE = SLOT_W'(4);

   logic [IDX_W-1:0]  idx;
   logic [SLOT_W-1:0] off;
   ctrl_t             ctrl_new;
   wave_t             wave_new;
   logic              unused_wbits;

   assign idx = addr[ADDR_W-1:SLOT_W];
   assign off = addr[SLOT_W-1:0];

   assign ctrl_new = '{nosync: wdata[C_NOSYNC], run: wdata[C_RUN], inv: wdata[C_INV],
                       od: wdata[C_OD], pin: wdata[C_PIN],
                       divh: wdata[C_DIVH_LSB +: DIVH_W], divl: wdata[C_DIVL_LSB +: DIVL_W]};
   assign wave_new = '{term: wdata[W_TERM_LSB +: CNT_W], fall: wdata[W_FALL_LSB +: CNT_W],
                       rise: wdata[W_RISE_LSB +: CNT_W]};
   assign unused_wbits = ^{wdata[31:18], wdata[15]};

   for (genvar c = 0; c < N_CH; c++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctrl_q[c] <= '0;
            wave_q[c] <= '0;
         end else if (wr && idx == IDX_W'(c)) begin
            if (off == OFF_CTRL) ctrl_q[c] <= ctrl_new;
            if (off == OFF_WAVE) wave_q[c] <= wave_new;
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int c = 0; c < N_CH; c++) begin
         if (idx == IDX_W'(c)) begin
            if (off == OFF_CTRL) begin
               rdata[C_DIVL_LSB +: DIVL_W] = ctrl_q[c].divl;
               rdata[C_DIVH_LSB +: DIVH_W] = ctrl_q[c].divh;
               rdata[C_PIN]    = ctrl_q[c].pin;
               rdata[C_OD]     = ctrl_q[c].od;
               rdata[C_INV]    = ctrl_q[c].inv;
               rdata[C_RUN]    = ctrl_q[c].run;
               rdata[C_NOSYNC] = ctrl_q[c].nosync;
            end else if (off == OFF_WAVE) begin
               rdata[W_RISE_LSB +: CNT_W] = wave_q[c].rise;
               rdata[W_FALL_LSB +: CNT_W] = wave_q[c].fall;
               rdata[W_TERM_LSB +: CNT_W] = wave_q[c].term;
            end
         end
      end
   end

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
   parameter int LIN_W = 8,
   parameter int POW_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [LIN_W-1:0] divl,
   input  logic [POW_W-1:0] divh,
   output logic             tick
);

   // the power-of-two stage counts up to 2^(2^POW_W - 1) - 1
   localparam int LIM_W = 1 << POW_W;

   logic [LIN_W-1:0] lin_q;
   logic [LIM_W-2:0] pow_q;
   logic [LIM_W-1:0] pow_lim;
   logic             lin_wrap;
   logic             pow_wrap;

   assign pow_lim  = (LIM_W'(1) << divh) - LIM_W'(1);
   // >= keeps the stages bounded if a smaller divider lands mid-count
   assign lin_wrap = lin_q >= divl;
   assign pow_wrap = {1'b0, pow_q} >= pow_lim;
   assign tick     = run && lin_wrap && pow_wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lin_q <= '0;
         pow_q <= '0;
      end else if (!run) begin
         lin_q <= '0;
         pow_q <= '0;
      end else if (lin_wrap) begin
         lin_q <= '0;
         pow_q <= pow_wrap ? '0 : pow_q + 1'b1;
      end else begin
         lin_q <= lin_q + 1'b1;
      end
   end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
   import pwm_bank_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  ctrl_t ctrl,
   input  wave_t wave,
   output logic  pin_o,
   output logic  pin_oe
);

   shadow_t          staged;
   shadow_t          act_q;
   logic [CNT_W-1:0] cnt_q;
   logic             tick;
   logic             wrap;
   logic             in_window;
   logic             shaped;

   assign staged = '{divh: ctrl.divh, divl: ctrl.divl, wave: wave};

   pwm_prescaler #(.LIN_W(DIVL_W), .POW_W(DIVH_W)) i_presc (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (ctrl.run),
      .divl (act_q.divl),
      .divh (act_q.divh),
      .tick (tick)
   );

   assign wrap = tick && (cnt_q >= act_q.wave.term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!ctrl.run) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      end
   end

   // shadow stage: free-flowing while gated or in immediate mode,
   // otherwise reloaded only where the counter wraps
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= '0;
      end else if (!ctrl.run || ctrl.nosync || wrap) begin
         act_q <= staged;
      end
   end

   always_comb begin
      if (act_q.wave.rise == act_q.wave.fall)
         in_window = 1'b1;
      else if (act_q.wave.rise < act_q.wave.fall)
         in_window = (cnt_q >= act_q.wave.rise) && (cnt_q < act_q.wave.fall);
      else
         in_window = (cnt_q >= act_q.wave.rise) || (cnt_q < act_q.wave.fall);
   end

   // gate, inversion and pin enable act on live control bits
   assign shaped = (ctrl.run && in_window) ^ ctrl.inv;
   assign pin_o  = ctrl.pin && shaped;
   assign pin_oe = ctrl.od ? !pin_o : 1'b1;

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
   import pwm_bank_pkg::*;
#(
   parameter int N_CH       = 16,
   parameter int SLOT_BYTES = 16,
   parameter int ADDR_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic [N_CH-1:0]   pwm_out,
   output logic [N_CH-1:0]   pwm_oe
);

   localparam int SLOT_W = $clog2(SLOT_BYTES);
   localparam int IDX_W  = ADDR_W - SLOT_W;

   if (N_CH < 1 || IDX_W < 1 || N_CH > (1 << IDX_W)) begin : g_bad_addr
      $error("pwm_bank: ADDR_W too narrow for N_CH channels");
   end
   if (SLOT_BYTES < 8 || (1 << SLOT_W) != SLOT_BYTES) begin : g_bad_slot
      $error("pwm_bank: SLOT_BYTES must be a power of two of at least 8");
   end

   ctrl_t [N_CH-1:0] ctrl_q;
   wave_t [N_CH-1:0] wave_q;

   pwm_regfile #(.N_CH(N_CH), .ADDR_W(ADDR_W), .SLOT_BYTES(SLOT_BYTES)) i_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (reg_wr),
      .addr  (reg_addr),
      .wdata (reg_wdata),
      .rdata (reg_rdata),
      .ctrl_q(ctrl_q),
      .wave_q(wave_q)
   );

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      pwm_channel i_ch (
         .clk   (clk),
         .rst_n (rst_n),
         .ctrl  (ctrl_q[c]),
         .wave  (wave_q[c]),
         .pin_o (pwm_out[c]),
         .pin_oe(pwm_oe[c])
      );
   end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
   import pwm_bank_pkg::*;
#(
   parameter int N_CH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input ctrl_t [N_CH-1:0] ctrl_q,
   input wave_t [N_CH-1:0] wave_q,
   input logic [N_CH-1:0]  pwm_out,
   input logic [N_CH-1:0]  pwm_oe
);

   for (genvar c = 0; c < N_CH; c++) begin : g_chk
      p_pin_off_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
         !ctrl_q[c].pin |-> (!pwm_out[c] && pwm_oe[c]));

      p_open_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
         ctrl_q[c].od |-> (pwm_oe[c] == !pwm_out[c]));

      p_push_pull_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !ctrl_q[c].od |-> pwm_oe[c]);

      p_gated_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (ctrl_q[c].pin && !ctrl_q[c].run && !ctrl_q[c].inv) |-> !pwm_out[c]);

      // settled immediate-mode channel with equal points stays active
      p_full_duty_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (ctrl_q[c].nosync && ctrl_q[c].run && ctrl_q[c].pin && !ctrl_q[c].inv &&
          $stable(ctrl_q[c]) && $stable(wave_q[c]) &&
          wave_q[c].rise == wave_q[c].fall) |-> pwm_out[c]);
   end

endmodule

bind pwm_bank pwm_bank_chk #(.N_CH(N_CH)) i_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .ctrl_q (ctrl_q),
   .wave_q (wave_q),
   .pwm_out(pwm_out),
   .pwm_oe (pwm_oe)
);

// File: tb/test_pwm_bank.sv
`timescale 1ns/1ps
module test_pwm_bank;

   localparam int N_CH = 16;
   localparam int AW   = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            reg_wr = 1'b0;
   logic [AW-1:0]   reg_addr = '0;
   logic [31:0]     reg_wdata = '0;
   logic [31:0]     reg_rdata;
   logic [N_CH-1:0] pwm_out;
   logic [N_CH-1:0] pwm_oe;

   int n_run  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   pwm_bank #(.N_CH(N_CH), .ADDR_W(AW)) i_pwm_bank (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
   );

   // channel, divl, divh, terminal, rise, fall
   localparam int VEC [5][6] = '{
      '{0,  0, 0,   9,  0,   3},
      '{3,  2, 1,   7,  2,   6},
      '{7,  1, 2,  15, 12,   4},
      '{15, 4, 0, 255, 10, 200},
      '{5,  0, 3,   3,  1,   2}
   };

   task automatic check(input string req, input longint act, input longint exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [31:0] cword(int divl, int divh, bit pin, bit od, bit inv,
                                         bit run, bit nosync);
      return 32'(divl) | (32'(divh) << 8) | (32'(pin) << 12) | (32'(od) << 13) |
             (32'(inv) << 14) | (32'(run) << 16) | (32'(nosync) << 17);
   endfunction

   function automatic logic [31:0] wword(int term, int rise, int fall);
      return 32'(rise) | (32'(fall) << 8) | (32'(term) << 24);
   endfunction

   task automatic wr(input int addr, input logic [31:0] data);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = AW'(addr); reg_wdata = data;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int addr, output logic [31:0] data);
      @(negedge clk);
      reg_addr = AW'(addr);
      #1 data = reg_rdata;
   endtask

   // waits for a rising edge, then counts cycles to the fall and the next rise
   task automatic measure(input int ch, output int per, output int hi);
      logic prev;
      bit   low_seen = 0;
      per = 0; hi = 0;
      prev = pwm_out[ch];
      for (int i = 0; i < 40000; i++) begin
         @(negedge clk);
         if (!prev && pwm_out[ch]) break;
         prev = pwm_out[ch];
      end
      for (int i = 0; i < 40000; i++) begin
         @(negedge clk);
         per++;
         if (!low_seen && !pwm_out[ch]) begin hi = per; low_seen = 1; end
         if (low_seen && pwm_out[ch]) break;
      end
   endtask

   task automatic cycles_to_rise(input int ch, output int n);
      logic prev = pwm_out[ch];
      n = 0;
      for (int i = 0; i < 40000; i++) begin
         @(negedge clk);
         n++;
         if (!prev && pwm_out[ch]) break;
         prev = pwm_out[ch];
      end
   endtask

   task automatic hold(input int ch, input bit eo, input bit eoe, input int n, input string req);
      int bad = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (pwm_out[ch] !== eo || pwm_oe[ch] !== eoe) bad++;
      end
      check(req, bad, 0);
   endtask

   initial begin
      #(5ns * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int per, hi, n;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("reset out R5", longint'(pwm_out), 0);
      check("reset oe R10", longint'(pwm_oe), 64'hFFFF);
      rd(0, d); check("reset ctrl R9", d, 0);

      // R9 register map and reserved bits
      wr(2 * 16, 32'hFFFF_FFFF);
      rd(2 * 16, d);     check("ctrl readback R9", d, 32'h0003_7FFF);
      wr(2 * 16 + 4, 32'hFFFF_FFFF);
      rd(2 * 16 + 4, d); check("wave readback R9", d, 32'hFF00_FFFF);
      rd(3 * 16 + 4, d); check("neighbour untouched R9", d, 0);
      wr(2 * 16, 0);

      // R1 / R2 table of settings
      for (int v = 0; v < 5; v++) begin
         int ch = VEC[v][0], l = VEC[v][1], h = VEC[v][2];
         int p = VEC[v][3], r = VEC[v][4], f = VEC[v][5];
         int t = (l + 1) << h;
         int eh = (r < f) ? (f - r) * t : (p + 1 - r + f) * t;
         wr(ch * 16 + 4, wword(p, r, f));
         wr(ch * 16, cword(l, h, 1, 0, 0, 0, 0));
         wr(ch * 16, cword(l, h, 1, 0, 0, 1, 0));
         measure(ch, per, hi);
         check($sformatf("period R1 vec%0d", v), per, t * (p + 1));
         check($sformatf("high R2 vec%0d", v), hi, eh);
      end

      // R3 equal points
      wr(16 + 4, wword(9, 5, 5));
      wr(16, cword(0, 0, 1, 0, 0, 1, 0));
      hold(1, 1, 1, 30, "full duty R3");

      // R4 gate low, writes accepted while gated
      wr(16, cword(0, 0, 1, 0, 0, 0, 0));
      hold(1, 0, 1, 20, "gated low R4");
      wr(16 + 4, wword(4, 0, 2));
      hold(1, 0, 1, 5, "gated after write R4");
      wr(16, cword(0, 0, 1, 0, 0, 1, 0));
      measure(1, per, hi);
      check("period after ungate R4", per, 5);
      check("high after ungate R4", hi, 2);

      // R6 immediate inversion
      wr(16, cword(0, 0, 1, 0, 0, 0, 0));
      wr(16, cword(0, 0, 1, 0, 1, 0, 0));
      check("invert on R6", pwm_out[1], 1);
      wr(16, cword(0, 0, 1, 0, 0, 0, 0));
      check("invert off R6", pwm_out[1], 0);

      // R5 pin disable
      wr(16 + 4, wword(9, 3, 3));
      wr(16, cword(0, 0, 0, 0, 0, 1, 0));
      hold(1, 0, 1, 20, "pin off R5");
      wr(16, cword(0, 0, 0, 1, 1, 1, 0));
      hold(1, 0, 1, 10, "pin off od inv R5");

      // R10 open drain
      wr(16, cword(0, 0, 1, 1, 0, 1, 0));
      hold(1, 1, 0, 10, "od high floats R10");
      wr(16, cword(0, 0, 1, 1, 0, 0, 0));
      hold(1, 0, 1, 10, "od low drives R10");

      // R7 deferred load
      wr(4 * 16 + 4, wword(19, 0, 10));
      wr(4 * 16, cword(0, 0, 1, 0, 0, 0, 0));
      wr(4 * 16, cword(0, 0, 1, 0, 0, 1, 0));
      measure(4, per, hi);
      check("old period R7", per, 20);
      wr(4 * 16 + 4, wword(9, 0, 5));
      cycles_to_rise(4, n);
      check("current period kept R7", n, 18);
      measure(4, per, hi);
      check("new period R7", per, 10);
      check("new high R7", hi, 5);

      // R8 immediate load
      wr(4 * 16, cword(0, 0, 1, 0, 0, 1, 1));
      measure(4, per, hi);
      wr(4 * 16 + 4, wword(9, 0, 2));
      @(negedge clk);
      check("immediate fall R8", pwm_out[4], 0);
      measure(4, per, hi);
      check("immediate period R8", per, 10);
      check("immediate high R8", hi, 2);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule